// File: doc/BRIEF.md
# Framebuffer Controller Register Bank

This block is the software-visible configuration store of a raster display controller. A host reaches it over a plain 32-bit word bus (strobe, write enable, byte address, write data, registered read data). It holds the visible width and height, the horizontal and vertical sync edges and total scan lengths, the frame buffer start address, a DMA burst length, a display-data-channel control word and a pixel-clock source select. Every value is presented on a dedicated output so that a separate scan-out engine can use it directly.

Beyond storage, the bank enforces a 32-byte alignment rule on the frame buffer start address and trims accepted addresses with a build-time mask. It offers a read-only mirror of the live start address and turns bit 0 of the control word (a hold-in-reset bit) into an engine enable. It emits single-cycle event pulses: a resize pulse when geometry or control changes while the engine runs, and an invalidate pulse whenever the scan-out engine must refetch the picture. An access that misses the map, or a write to the mirror, raises a one-cycle error flag.

Top module: `fbc_regbank`

## Requirements
- R1: After reset the control word reads 1, the width reads 640, the height reads 480 and every other slot, including the start address, reads 0; engine_enable is 0.
- R2: Word index = byte address bits above bit 1; the two low address bits are ignored. Indices 2,3,4,6,7,8,11,12,13 (sync edges, totals, burst, data-channel word, clock select) store the full 32-bit write value unchecked, read it back and drive it on their output port.
- R3: A write to index 9 (start address) whose data has any of bits 4:0 set changes nothing and produces no invalidate pulse.
- R4: An accepted write to index 9 stores data AND BASE_MASK and produces an invalidate pulse in the cycle after the write; fb_base bits 4:0 are always 0.
- R5: Index 10 reads the current start address; a write to it changes no register and raises bus_err.
- R6: A write to index 0 (control), 1 (width) or 5 (height) produces resize_pulse in the cycle after the write only when control bit 0 is 0 once the write has taken effect; no other write produces it.
- R7: invalidate_pulse is high in every cycle in which resize_pulse is high.
- R8: An access to an index of 14 or more reads 0, a write there changes no register, and bus_err is high for the one cycle after such an access.
- R9: bus_rdata is updated only in the cycle after a read strobe and holds its value otherwise.
- R10: engine_enable is the inverse of control bit 0 and changes only after a control write.
- R11: After a single isolated write, resize_pulse, invalidate_pulse and bus_err are each high for at most one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_err | output | 1 | One-cycle error flag for a bad access |
| engine_enable | output | 1 | Scan-out engine may run |
| resize_pulse | output | 1 | Geometry or control changed while enabled |
| invalidate_pulse | output | 1 | Picture must be refetched |
| h_active | output | 32 | Visible width |
| h_sync_on | output | 32 | Horizontal sync start |
| h_sync_off | output | 32 | Horizontal sync end |
| h_total | output | 32 | Horizontal scan length |
| v_active | output | 32 | Visible height |
| v_sync_on | output | 32 | Vertical sync start |
| v_sync_off | output | 32 | Vertical sync end |
| v_total | output | 32 | Vertical scan length |
| fb_base | output | 32 | Frame buffer start address |
| burst_len | output | 32 | DMA burst length |
| ddc_word | output | 32 | Display-data-channel control word |
| clk_select | output | 32 | Pixel clock source select |

## Verification
The bench builds the bank with the default 8-bit byte address, giving 64 word indices, so every in-map and out-of-map index is read after reset and written and read again, and every one of the 31 misaligned low-bit patterns of the start address is tried. BASE_MASK is set to 0x0FFF_FFC0 instead of all ones, which clears bit 5 and the top nibble; that makes the masking of accepted start addresses observable, where the all-ones default would hide it.

// File: rtl/fbc_regs_pkg.sv
// Shared definitions for the framebuffer register bank.
// Assumes a 14-word map; the index order is the software-visible map.
package fbc_regs_pkg;

    localparam int NUM_REGS = 14;
    localparam int DATA_W   = 32;

    typedef enum logic [3:0] {
        IX_CTRL     = 4'd0,
        IX_HACT     = 4'd1,
        IX_HSON     = 4'd2,
        IX_HSOFF    = 4'd3,
        IX_HTOT     = 4'd4,
        IX_VACT     = 4'd5,
        IX_VSON     = 4'd6,
        IX_VSOFF    = 4'd7,
        IX_VTOT     = 4'd8,
        IX_BASE     = 4'd9,
        IX_BASE_ACT = 4'd10,
        IX_BURST    = 4'd11,
        IX_DDC      = 4'd12,
        IX_CLKSEL   = 4'd13
    } reg_idx_e;

    typedef struct packed {
        logic     hit;   // strobe to an index inside the map
        logic     bad;   // strobe outside the map, or write to the mirror
        reg_idx_e idx;   // decoded index, valid when hit
    } decode_t;

endpackage

// File: rtl/fbc_addr_decode.sv
// Address decoder: turns a byte address and strobe into a word index,
// an in-map hit and an error condition. Purely combinational.
// Assumes ADDR_W >= 6 so the 14-entry map fits.
module fbc_addr_decode
    import fbc_regs_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              sel,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    output decode_t           dec
);
    localparam int WORD_W = ADDR_W - 2;

    logic [WORD_W-1:0] word;
    logic              in_range;
    logic [1:0]        unused_lo;

    assign word      = addr[ADDR_W-1:2];
    assign unused_lo = addr[1:0];

    // Classify the access against the map.
    always_comb begin
        in_range = (word < WORD_W'(NUM_REGS));
        dec.hit  = sel && in_range;
        dec.idx  = in_range ? reg_idx_e'(word[3:0]) : IX_CTRL;
        dec.bad  = sel && (!in_range || (we && word == WORD_W'(IX_BASE_ACT)));
    end

endmodule

// File: rtl/fbc_reg_store.sv
// Register storage: one 32-bit word per map slot. Plain slots take any
// write; the start-address slot enforces alignment and masking; the
// mirror slot copies the start address and holds no state of its own.
module fbc_reg_store
    import fbc_regs_pkg::*;
#(
    parameter logic [31:0] BASE_MASK = 32'hFFFF_FFFF,
    parameter logic [31:0] RST_HRES  = 32'd640,
    parameter logic [31:0] RST_VRES  = 32'd480
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  reg_idx_e                        wr_idx,
    input  logic [DATA_W-1:0]               wdata,
    output logic [NUM_REGS-1:0][DATA_W-1:0] regs,
    output logic                            base_accept
);
    // Aligned start-address writes are the only ones taken at index 9.
    assign base_accept = wr_en && (wr_idx == IX_BASE) && (wdata[4:0] == 5'd0);

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_slot
        localparam logic [DATA_W-1:0] RV =
            (i == int'(IX_CTRL)) ? 32'd1 :
            (i == int'(IX_HACT)) ? RST_HRES :
            (i == int'(IX_VACT)) ? RST_VRES : 32'd0;

        if (i == int'(IX_BASE_ACT)) begin : g_mirror
            assign regs[i] = regs[IX_BASE];
        end else if (i == int'(IX_BASE)) begin : g_base
            logic [DATA_W-1:0] q;
            // Hold the start address; accept only aligned writes.
            always_ff @(posedge clk) begin
                if (!rst_n)           q <= RV;
                else if (base_accept) q <= wdata & BASE_MASK;
            end
            assign regs[i] = q;
        end else begin : g_plain
            logic [DATA_W-1:0] q;
            // Hold a plain configuration word.
            always_ff @(posedge clk) begin
                if (!rst_n)                                  q <= RV;
                else if (wr_en && wr_idx == reg_idx_e'(i))   q <= wdata;
            end
            assign regs[i] = q;
        end
    end

endmodule

// File: rtl/fbc_event_gen.sv
// Event generator: registered single-cycle resize and invalidate pulses.
// Resize fires for control/width/height writes when the engine is
// enabled after the write; invalidate fires with resize and on any
// accepted start-address write.
module fbc_event_gen
    import fbc_regs_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     wr_en,
    input  reg_idx_e wr_idx,
    input  logic     wdata_b0,
    input  logic     ctrl_hold_q,
    input  logic     base_accept,
    output logic     resize_o,
    output logic     inval_o
);
    logic resize_d;

    // Decide whether this write changes live geometry.
    always_comb begin
        resize_d = 1'b0;
        if (wr_en) begin
            if (wr_idx == IX_CTRL)
                resize_d = !wdata_b0;
            else if (wr_idx == IX_HACT || wr_idx == IX_VACT)
                resize_d = !ctrl_hold_q;
        end
    end

    // Register the pulses so they last exactly one cycle per write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resize_o <= 1'b0;
            inval_o  <= 1'b0;
        end else begin
            resize_o <= resize_d;
            inval_o  <= resize_d || base_accept;
        end
    end

endmodule

// File: rtl/fbc_regbank.sv
// Framebuffer controller register bank (top). Decodes bus accesses,
// stores the configuration, registers read data and error flag, and
// presents every field to the scan-out engine.
// Assumes one access per cycle and full-word accesses only.
module fbc_regbank
    import fbc_regs_pkg::*;
#(
    parameter int          ADDR_W    = 8,
    parameter logic [31:0] BASE_MASK = 32'hFFFF_FFFF,
    parameter logic [31:0] RST_HRES  = 32'd640,
    parameter logic [31:0] RST_VRES  = 32'd480
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_err,
    output logic              engine_enable,
    output logic              resize_pulse,
    output logic              invalidate_pulse,
    output logic [31:0]       h_active,
    output logic [31:0]       h_sync_on,
    output logic [31:0]       h_sync_off,
    output logic [31:0]       h_total,
    output logic [31:0]       v_active,
    output logic [31:0]       v_sync_on,
    output logic [31:0]       v_sync_off,
    output logic [31:0]       v_total,
    output logic [31:0]       fb_base,
    output logic [31:0]       burst_len,
    output logic [31:0]       ddc_word,
    output logic [31:0]       clk_select
);
    decode_t                         dec;
    logic                            wr_en;
    logic                            base_accept;
    logic [NUM_REGS-1:0][DATA_W-1:0] regs;

    fbc_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .sel  (bus_sel),
        .we   (bus_we),
        .addr (bus_addr),
        .dec  (dec)
    );

    assign wr_en = dec.hit && bus_we;

    fbc_reg_store #(
        .BASE_MASK (BASE_MASK),
        .RST_HRES  (RST_HRES),
        .RST_VRES  (RST_VRES)
    ) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_idx      (dec.idx),
        .wdata       (bus_wdata),
        .regs        (regs),
        .base_accept (base_accept)
    );

    fbc_event_gen u_evt (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_idx      (dec.idx),
        .wdata_b0    (bus_wdata[0]),
        .ctrl_hold_q (regs[IX_CTRL][0]),
        .base_accept (base_accept),
        .resize_o    (resize_pulse),
        .inval_o     (invalidate_pulse)
    );

    // Capture read data one cycle after a read strobe; hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bus_rdata <= '0;
        else if (bus_sel && !bus_we)
            bus_rdata <= dec.hit ? regs[dec.idx] : '0;
    end

    // Flag a bad access for exactly the following cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) bus_err <= 1'b0;
        else        bus_err <= dec.bad;
    end

    assign engine_enable = !regs[IX_CTRL][0];
    assign h_active      = regs[IX_HACT];
    assign h_sync_on     = regs[IX_HSON];
    assign h_sync_off    = regs[IX_HSOFF];
    assign h_total       = regs[IX_HTOT];
    assign v_active      = regs[IX_VACT];
    assign v_sync_on     = regs[IX_VSON];
    assign v_sync_off    = regs[IX_VSOFF];
    assign v_total       = regs[IX_VTOT];
    assign fb_base       = regs[IX_BASE];
    assign burst_len     = regs[IX_BURST];
    assign ddc_word      = regs[IX_DDC];
    assign clk_select    = regs[IX_CLKSEL];

endmodule

// File: rtl/fbc_regbank_chk.sv
// Property checker for fbc_regbank, attached by bind below.
module fbc_regbank_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_we,
    input logic [ADDR_W-3:0] bus_word,
    input logic [4:0]        wdata_lo,
    input logic [31:0]       bus_rdata,
    input logic              bus_err,
    input logic              engine_enable,
    input logic              resize_pulse,
    input logic              invalidate_pulse,
    input logic [4:0]        base_lo,
    input logic [31:0]       fb_base
);
    p_inval_with_resize_r7: assert property (@(posedge clk) disable iff (!rst_n)
        resize_pulse |-> invalidate_pulse);

    p_resize_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        resize_pulse |-> ($past(bus_sel && bus_we) && engine_enable));

    p_misaligned_base_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && bus_word == (ADDR_W-2)'(9) && (wdata_lo != 5'd0))
        |=> $stable(fb_base));

    p_base_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
        base_lo == 5'd0);

    p_err_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> $past(bus_sel));

    p_rdata_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_sel && !bus_we) |-> $stable(bus_rdata));

    p_enable_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_sel && bus_we) |-> $stable(engine_enable));

endmodule

bind fbc_regbank fbc_regbank_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .bus_sel          (bus_sel),
    .bus_we           (bus_we),
    .bus_word         (bus_addr[ADDR_W-1:2]),
    .wdata_lo         (bus_wdata[4:0]),
    .bus_rdata        (bus_rdata),
    .bus_err          (bus_err),
    .engine_enable    (engine_enable),
    .resize_pulse     (resize_pulse),
    .invalidate_pulse (invalidate_pulse),
    .base_lo          (fb_base[4:0]),
    .fb_base          (fb_base)
);

// File: tb/fbc_regbank_bench.sv
`timescale 1ns/1ps
module fbc_regbank_bench;
    localparam int          ADDR_W = 8;
    localparam int          NIDX   = 1 << (ADDR_W - 2);
    localparam logic [31:0] MASK   = 32'h0FFF_FFC0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err, engine_enable, resize_pulse, invalidate_pulse;
    logic [31:0] h_active, h_sync_on, h_sync_off, h_total;
    logic [31:0] v_active, v_sync_on, v_sync_off, v_total;
    logic [31:0] fb_base, burst_len, ddc_word, clk_select;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    logic [31:0] m [14];

    always #4 clk = ~clk;

    fbc_regbank #(.ADDR_W(ADDR_W), .BASE_MASK(MASK)) u_fbc_regbank (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_err(bus_err), .engine_enable(engine_enable),
        .resize_pulse(resize_pulse), .invalidate_pulse(invalidate_pulse),
        .h_active(h_active), .h_sync_on(h_sync_on), .h_sync_off(h_sync_off),
        .h_total(h_total), .v_active(v_active), .v_sync_on(v_sync_on),
        .v_sync_off(v_sync_off), .v_total(v_total), .fb_base(fb_base),
        .burst_len(burst_len), .ddc_word(ddc_word), .clk_select(clk_select)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_rd(input int idx);
        if (idx >= 14) return 32'd0;
        if (idx == 10) return m[9];
        return m[idx];
    endfunction

    // One write; pulses and error are checked in the cycle after it.
    task automatic wr(input int idx, input logic [31:0] d, input logic [1:0] lo);
        logic er, ei, ee;
        ee = (idx >= 14) || (idx == 10);
        er = 1'b0;
        if (idx == 0) er = !d[0];
        else if (idx == 1 || idx == 5) er = !m[0][0];
        ei = er || (idx == 9 && d[4:0] == 5'd0);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1;
        bus_addr = {ADDR_W'(idx)} << 2 | ADDR_W'(lo);
        bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
        chk("R6 resize after write", 32'(resize_pulse), 32'(er));
        chk("R7/R4 invalidate after write", 32'(invalidate_pulse), 32'(ei));
        chk("R8/R5 error after write", 32'(bus_err), 32'(ee));
        if (idx < 14 && idx != 10) begin
            if (idx != 9) m[idx] = d;
            else if (d[4:0] == 5'd0) m[9] = d & MASK;
        end
    endtask

    task automatic rd_chk(input int idx, input string tag);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0;
        bus_addr = ADDR_W'(idx) << 2;
        @(negedge clk);
        bus_sel = 1'b0;
        chk(tag, bus_rdata, exp_rd(idx));
        chk("R8 read error flag", 32'(bus_err), 32'(idx >= 14));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 14; i++) m[i] = 32'd0;
        m[0] = 32'd1; m[1] = 32'd640; m[5] = 32'd480;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state at the ports and over the whole index space.
        chk("R1 engine_enable", 32'(engine_enable), 32'd0);
        chk("R1 h_active", h_active, 32'd640);
        chk("R1 v_active", v_active, 32'd480);
        chk("R1 fb_base", fb_base, 32'd0);
        for (int i = 0; i < NIDX; i++) rd_chk(i, "R1/R8 reset read");

        // R2: plain slots store full words; low address bits ignored.
        for (int i = 2; i < 14; i++) begin
            if (i == 5 || i == 9 || i == 10) continue;
            wr(i, 32'hA5C3_0F00 ^ (32'(i) * 32'h0101_0101), 2'(i));
            rd_chk(i, "R2 plain readback");
        end
        chk("R2 h_sync_on", h_sync_on, m[2]);
        chk("R2 h_sync_off", h_sync_off, m[3]);
        chk("R2 h_total", h_total, m[4]);
        chk("R2 v_sync_on", v_sync_on, m[6]);
        chk("R2 v_sync_off", v_sync_off, m[7]);
        chk("R2 v_total", v_total, m[8]);
        chk("R2 burst_len", burst_len, m[11]);
        chk("R2 ddc_word", ddc_word, m[12]);
        chk("R2 clk_select", clk_select, m[13]);

        // R6: geometry writes while held in reset give no resize.
        wr(1, 32'd1024, 2'd0);
        chk("R2 h_active", h_active, 32'd1024);

        // R6, R10, R11: release the hold bit, then pulses drop.
        wr(0, 32'd0, 2'd0);
        chk("R10 enable after release", 32'(engine_enable), 32'd1);
        @(negedge clk);
        chk("R11 resize one cycle", 32'(resize_pulse), 32'd0);
        chk("R11 invalidate one cycle", 32'(invalidate_pulse), 32'd0);
        wr(1, 32'd800, 2'd0);
        wr(5, 32'd600, 2'd0);
        chk("R2 v_active", v_active, 32'd600);
        wr(0, 32'd3, 2'd0);
        chk("R10 enable off", 32'(engine_enable), 32'd0);
        wr(5, 32'd768, 2'd0);
        wr(0, 32'd2, 2'd0);
        chk("R10 enable on", 32'(engine_enable), 32'd1);
        rd_chk(0, "R10 control readback");

        // R3: every misaligned low-bit pattern is dropped.
        wr(9, 32'hF234_5660, 2'd0);
        for (int lo = 1; lo < 32; lo++) begin
            wr(9, 32'h0000_1000 | 32'(lo), 2'd0);
            chk("R3 base unchanged", fb_base, m[9]);
        end
        // R4, R5: aligned writes are masked; mirror follows.
        for (int k = 0; k < 8; k++) begin
            wr(9, {k[2:0], 29'h0ABC_DE0} << 0 ^ (32'(k) << 5), 2'd0);
            chk("R4 base masked", fb_base, m[9]);
            chk("R4 base aligned", 32'(fb_base[4:0]), 32'd0);
            rd_chk(10, "R5 mirror read");
        end
        wr(10, 32'h0000_0400, 2'd0);
        chk("R5 mirror write ignored", fb_base, m[9]);
        @(negedge clk);
        chk("R11 error one cycle", 32'(bus_err), 32'd0);

        // R8: writes off the map change nothing.
        for (int i = 14; i < NIDX; i++) wr(i, 32'hDEAD_BEEF, 2'd0);
        for (int i = 0; i < 14; i++) rd_chk(i, "R8 map unchanged");

        // R9: read data holds through idle and write cycles.
        rd_chk(11, "R9 read latency");
        @(negedge clk);
        chk("R9 hold idle", bus_rdata, m[11]);
        wr(12, 32'h1357_9BDF, 2'd0);
        chk("R9 hold over write", bus_rdata, m[11]);

        finish_run();
    end
endmodule